// File: doc/BRIEF.md
# Transmit Segment Command Parser

This block sits behind a host-writable transmit data port. Each word the host writes arrives as a 32-bit word on `wr_data` with a one-cycle `wr_valid` strobe. The block splits the words into segments. Every segment opens with a two-word header. The first header word carries the segment byte count, the offset of the first payload byte, the first/last segment flags, an end-alignment code and an interrupt-on-completion request. The second header word carries a 16-bit packet tag, which is used only on a first segment.

The parser strips the leading offset bytes and outputs the payload as packed bytes, least significant byte first. The output is one registered word per accepted data word, with a lane-keep mask and a last marker. It then consumes any alignment pad words. When the last segment of a packet completes, it pushes a status entry (tag and total packet byte count) into a status FIFO, which the host drains through a pop strobe. A word-usage counter models the fill of the transmit data store. Writes that arrive while it is at capacity are dropped and flagged. A clear strobe re-synchronises the parser.

Top module: `txcmd_parser`

## Requirements
- R1: After a synchronous reset, `out_valid`, `ovf_irq`, `done_irq` and `sts_full_irq` are 0 and `sts_level` is 0.
- R2: The first accepted word of a segment is header A and the second is header B. Neither produces output. Header A fields: bits 10:0 byte count, bits 20:16 start offset, bit 12 last segment, bit 13 first segment, bits 25:24 alignment code, bit 31 completion interrupt. All other bits are ignored.
- R3: In a data word, output bytes are taken least significant first and packed from lane 0. While the remaining offset is 4 or more, a whole word is discarded with no output and the offset drops by 4. A remaining offset of 1 to 3 drops that many low bytes of the next data word.
- R4: Each data word outputs min(4 − offset, remaining count) bytes. `out_keep` has exactly that many low bits set and unused lanes of `out_data` read 0. `out_last` is 1 on the word carrying the final byte of a segment whose last flag is set.
- R5: Alignment code 1 pads the segment's data word count, ceil((count+offset)/4), up to a multiple of 4. Code 2 pads it up to a multiple of 8. Codes 0 and 3 add no padding. Pad words produce no output and the segment ends on the final pad word.
- R6: The status entry pushed when a last segment ends holds the tag (header B bits 31:16 of the packet's first segment) in bits 31:16. It holds the packet's total payload byte count over all its segments in bits 15:0. Header B of a non-first segment is ignored.
- R7: `done_irq` pulses for one cycle when a segment whose header A bit 31 is set ends, whether or not it is the last segment.
- R8: `sts_full_irq` pulses for one cycle when a push brings `sts_level` to STS_DEPTH. A push while the FIFO is full is discarded, leaving level and contents unchanged.
- R9: The usage counter counts accepted words. It returns to 0 when a last segment ends. A write while it equals DATA_WORDS is dropped without effect on the parser, and `ovf_irq` pulses for one cycle.
- R10: A `clr` cycle returns the parser to expecting header A and zeroes the usage counter. A write in the same cycle is ignored.
- R11: A `sts_rd` pulse on a non-empty FIFO loads the oldest entry into `sts_data` and decrements `sts_level`. On an empty FIFO it leaves `sts_data` and `sts_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Parser clear strobe |
| wr_valid | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word |
| out_valid | output | 1 | Output word holds payload bytes |
| out_data | output | 32 | Packed payload bytes, lane 0 first |
| out_keep | output | 4 | Valid lanes of `out_data` |
| out_last | output | 1 | Word holds the final byte of a packet |
| ovf_irq | output | 1 | Dropped-write pulse |
| done_irq | output | 1 | Segment completion pulse |
| sts_full_irq | output | 1 | Status FIFO became full pulse |
| sts_rd | input | 1 | Status pop strobe |
| sts_data | output | 32 | Last popped status entry |
| sts_level | output | $clog2(STS_DEPTH+1) | Status entries held |

## Verification
Every result of a write is registered at the clock edge that captures the word. Output bytes, keep, last, the interrupt pulses and the new status level are therefore all due one edge after `wr_valid` is presented, and the interrupts last only that one cycle. A popped status entry appears on `sts_data` at the edge that samples `sts_rd`. The bench drives each strobe for one cycle from a falling edge and samples on the following falling edge, half a cycle after the edge where the result lands and before the next edge can clear a pulse.

// File: rtl/txp_pkg.sv
package txp_pkg;

  typedef enum logic [1:0] {
    PS_HDR_A = 2'd0,
    PS_HDR_B = 2'd1,
    PS_DATA  = 2'd2
  } pstate_e;

  localparam int LANES    = 4;
  localparam int CNT_W    = 11;
  localparam int OFF_W    = 5;
  localparam int PAD_W    = 3;
  localparam int LEN_W    = 16;
  localparam int TAG_W    = 16;
  localparam int STS_W    = TAG_W + LEN_W;

  localparam int A_LAST   = 12;
  localparam int A_FIRST  = 13;
  localparam int A_IOC    = 31;
  localparam int A_OFF_LO = 16;
  localparam int A_ALN_LO = 24;

endpackage

// File: rtl/txp_seg_parser.sv
module txp_seg_parser
  import txp_pkg::*;
#(
  parameter int DATA_WORDS = 1152
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [31:0]       wr_data,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic [LANES-1:0]  out_keep,
  output logic              out_last,
  output logic              ovf_irq,
  output logic              done_irq,
  output logic              push_valid,
  output logic [STS_W-1:0]  push_data
);

  localparam int UW = $clog2(DATA_WORDS + 1);

  pstate_e            st;
  logic [UW-1:0]      usage;
  logic [CNT_W-1:0]   a_cnt, r_rem;
  logic [OFF_W-1:0]   a_off, r_off;
  logic [1:0]         a_align;
  logic               a_first, a_last, a_ioc;
  logic [PAD_W-1:0]   r_pad;
  logic [TAG_W-1:0]   r_tag;
  logic [LEN_W-1:0]   r_len;

  // Write acceptance
  logic full, accept;
  assign full   = (usage == UW'(DATA_WORDS));
  assign accept = wr_valid && !full;

  // Alignment pad from the header fields
  logic [4:0]       sum5;
  logic [2:0]       wl;
  logic [PAD_W-1:0] pad_calc;
  assign sum5 = a_cnt[4:0] + a_off + 5'd3;
  assign wl   = 3'(sum5 >> 2);
  always_comb begin
    case (a_align)
      2'd1:    pad_calc = {1'b0, 2'(2'd0 - wl[1:0])};
      2'd2:    pad_calc = 3'd0 - wl;
      default: pad_calc = '0;
    endcase
  end

  // Data word decode
  logic             off_big;
  logic [2:0]       avail, take;
  logic [CNT_W-1:0] rem_n;
  logic [OFF_W-1:0] off_n;
  logic [PAD_W-1:0] pad_n;
  logic             seg_end;
  logic [31:0]      shifted, masked;
  logic [LANES-1:0] lane_en;

  assign off_big = (r_off[OFF_W-1:2] != '0);
  assign avail   = 3'd4 - {1'b0, r_off[1:0]};
  always_comb begin
    if (off_big)                              take = 3'd0;
    else if (r_rem < CNT_W'(avail))           take = r_rem[2:0];
    else                                      take = avail;
  end
  assign rem_n   = r_rem - CNT_W'(take);
  assign off_n   = off_big ? (r_off - OFF_W'(4)) : '0;
  assign pad_n   = (!off_big && r_rem == '0 && r_pad != '0) ? (r_pad - 1'b1) : r_pad;
  assign seg_end = !off_big && (rem_n == '0) && (pad_n == '0);
  assign shifted = wr_data >> {r_off[1:0], 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g]         = (take > 3'(g));
    assign masked[8*g +: 8]   = lane_en[g] ? shifted[8*g +: 8] : 8'h00;
  end

  assign push_valid = !rst && !clr && accept && (st == PS_DATA) && seg_end && a_last;
  assign push_data  = {r_tag, r_len + LEN_W'(take)};

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    out_last  <= 1'b0;
    ovf_irq   <= 1'b0;
    done_irq  <= 1'b0;
    if (rst) begin
      st       <= PS_HDR_A;
      usage    <= '0;
      a_cnt    <= '0;
      a_off    <= '0;
      a_align  <= '0;
      a_first  <= 1'b0;
      a_last   <= 1'b0;
      a_ioc    <= 1'b0;
      r_rem    <= '0;
      r_off    <= '0;
      r_pad    <= '0;
      r_tag    <= '0;
      r_len    <= '0;
      out_data <= '0;
      out_keep <= '0;
    end else if (clr) begin
      st    <= PS_HDR_A;
      usage <= '0;
    end else if (wr_valid && full) begin
      ovf_irq <= 1'b1;
    end else if (accept) begin
      usage <= usage + 1'b1;
      case (st)
        PS_HDR_A: begin
          a_cnt   <= wr_data[CNT_W-1:0];
          a_off   <= wr_data[A_OFF_LO +: OFF_W];
          a_align <= wr_data[A_ALN_LO +: 2];
          a_first <= wr_data[A_FIRST];
          a_last  <= wr_data[A_LAST];
          a_ioc   <= wr_data[A_IOC];
          st      <= PS_HDR_B;
        end
        PS_HDR_B: begin
          if (a_first) begin
            r_tag <= wr_data[31:16];
            r_len <= '0;
          end
          r_rem <= a_cnt;
          r_off <= a_off;
          r_pad <= pad_calc;
          st    <= PS_DATA;
        end
        default: begin
          r_rem <= rem_n;
          r_off <= off_n;
          r_pad <= pad_n;
          if (take != 3'd0) begin
            out_valid <= 1'b1;
            out_data  <= masked;
            out_keep  <= lane_en;
            out_last  <= a_last && (rem_n == '0);
            r_len     <= r_len + LEN_W'(take);
          end
          if (seg_end) begin
            st <= PS_HDR_A;
            if (a_ioc)  done_irq <= 1'b1;
            if (a_last) usage    <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/txp_sts_fifo.sv
module txp_sts_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full_irq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign do_push = push && (level != LW'(DEPTH));
  assign do_pop  = pop && (level != '0);

  // Storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (do_pop) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    full_irq <= 1'b0;
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop) begin
        level <= level + 1'b1;
        if (level == LW'(DEPTH - 1)) full_irq <= 1'b1;
      end else if (do_pop && !do_push) begin
        level <= level - 1'b1;
      end
    end
  end

endmodule

// File: rtl/txcmd_parser.sv
module txcmd_parser
  import txp_pkg::*;
#(
  parameter int DATA_WORDS = 1152,
  parameter int STS_DEPTH  = 512
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clr,
  input  logic                             wr_valid,
  input  logic [31:0]                      wr_data,
  output logic                             out_valid,
  output logic [31:0]                      out_data,
  output logic [3:0]                       out_keep,
  output logic                             out_last,
  output logic                             ovf_irq,
  output logic                             done_irq,
  output logic                             sts_full_irq,
  input  logic                             sts_rd,
  output logic [31:0]                      sts_data,
  output logic [$clog2(STS_DEPTH+1)-1:0]   sts_level
);

  logic             push_valid;
  logic [STS_W-1:0] push_data;

  txp_seg_parser #(.DATA_WORDS(DATA_WORDS)) i_seg (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_keep   (out_keep),
    .out_last   (out_last),
    .ovf_irq    (ovf_irq),
    .done_irq   (done_irq),
    .push_valid (push_valid),
    .push_data  (push_data)
  );

  txp_sts_fifo #(.DEPTH(STS_DEPTH), .WIDTH(STS_W)) i_sts (
    .clk       (clk),
    .rst       (rst),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (sts_rd),
    .rd_data   (sts_data),
    .level     (sts_level),
    .full_irq  (sts_full_irq)
  );

endmodule

// File: rtl/txcmd_parser_chk.sv
module txcmd_parser_chk #(
  parameter int STS_DEPTH = 512
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             clr,
  input logic                             wr_valid,
  input logic                             out_valid,
  input logic [3:0]                       out_keep,
  input logic                             out_last,
  input logic                             ovf_irq,
  input logic                             done_irq,
  input logic                             sts_full_irq,
  input logic                             sts_rd,
  input logic [31:0]                      sts_data,
  input logic [$clog2(STS_DEPTH+1)-1:0]   sts_level
);

  localparam int LW = $clog2(STS_DEPTH + 1);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> ($past(wr_valid) && !$past(clr)));

  // R9
  ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (!out_valid && !done_irq));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R4
  keep_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_keep == 4'h1 || out_keep == 4'h3 || out_keep == 4'h7 || out_keep == 4'hF));

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sts_level <= LW'(STS_DEPTH));

  // R8
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    sts_full_irq |-> (sts_level == LW'(STS_DEPTH)));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sts_rd) && ($past(sts_level) == '0) && !$past(rst)) |-> $stable(sts_data));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(wr_valid) && !$past(clr)));

  // R10
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (!out_valid && !done_irq && !ovf_irq));

endmodule

bind txcmd_parser txcmd_parser_chk #(.STS_DEPTH(STS_DEPTH)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .clr          (clr),
  .wr_valid     (wr_valid),
  .out_valid    (out_valid),
  .out_keep     (out_keep),
  .out_last     (out_last),
  .ovf_irq      (ovf_irq),
  .done_irq     (done_irq),
  .sts_full_irq (sts_full_irq),
  .sts_rd       (sts_rd),
  .sts_data     (sts_data),
  .sts_level    (sts_level)
);

// File: tb/test_txcmd_parser.sv
module test_txcmd_parser;

  localparam int DW = 12;
  localparam int SD = 4;
  localparam int NV = 24;

  logic        clk = 1'b0;
  logic        rst, clr, wr_valid, sts_rd;
  logic [31:0] wr_data;
  logic        out_valid, out_last, ovf_irq, done_irq, sts_full_irq;
  logic [31:0] out_data, sts_data;
  logic [3:0]  out_keep;
  logic [2:0]  sts_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  txcmd_parser #(.DATA_WORDS(DW), .STS_DEPTH(SD)) i_txcmd_parser (
    .clk(clk), .rst(rst), .clr(clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .ovf_irq(ovf_irq), .done_irq(done_irq), .sts_full_irq(sts_full_irq),
    .sts_rd(sts_rd), .sts_data(sts_data), .sts_level(sts_level)
  );

  // {wr word, exp valid, exp data, exp keep, exp last, exp done}
  localparam logic [70:0] VEC [NV] = '{
    {32'h80013006, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R2 hdr A, off 1, cnt 6, ioc
    {32'hBEEF1234, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R2 hdr B tag BEEF
    {32'h44332211, 1'b1, 32'h00443322, 4'h7, 1'b0, 1'b0}, // R3 drop 1 low byte
    {32'h88776655, 1'b1, 32'h00776655, 4'h7, 1'b1, 1'b1}, // R4 R7 partial last
    {32'h00002005, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // first seg, cnt 5
    {32'h12340000, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R6 tag 1234
    {32'h04030201, 1'b1, 32'h04030201, 4'hF, 1'b0, 1'b0},
    {32'h00000005, 1'b1, 32'h00000005, 4'h1, 1'b0, 1'b0}, // not last seg
    {32'h01061003, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // last seg, off 6, cnt 3, align 1
    {32'hDEAD0000, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R6 ignored B
    {32'hCAFEF00D, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R3 whole offset word
    {32'h0C0B0A09, 1'b1, 32'h00000C0B, 4'h3, 1'b0, 1'b0},
    {32'h100F0E0D, 1'b1, 32'h0000000D, 4'h1, 1'b1, 1'b0},
    {32'hFFFFFFFF, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R5 one pad word
    {32'h02003004, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // align 2, cnt 4
    {32'h00770000, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'hAABBCCDD, 1'b1, 32'hAABBCCDD, 4'hF, 1'b1, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}, // R5 seven pad words
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0},
    {32'h5A5A5A5A, 1'b0, 32'h0,        4'h0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [31:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; wr_valid = 1'b0; sts_rd = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!out_valid && !ovf_irq && !done_irq && !sts_full_irq && sts_level == 0,
        "R1 reset outputs", {out_valid, ovf_irq, done_irq, sts_full_irq, 25'd0, sts_level}, 32'h0);

    // Stream table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      wr(v[70:39]);
      if (v[38])
        chk(out_valid && out_data == v[37:6] && out_keep == v[5:2] && out_last == v[1] && done_irq == v[0],
            $sformatf("R2/R3/R4 stream row %0d", i), out_data, v[37:6]);
      else
        chk(!out_valid && done_irq == v[0], $sformatf("R2/R5 silent row %0d", i),
            {30'd0, out_valid, done_irq}, {31'd0, v[0]});
    end
    chk(sts_level == 3, "R5 R6 status level after three packets", 32'(sts_level), 32'd3);

    // R6 R11 ordered pops
    pop(); chk(sts_data == 32'hBEEF0006, "R6 entry 0", sts_data, 32'hBEEF0006);
    pop(); chk(sts_data == 32'h12340008, "R6 multi-segment entry", sts_data, 32'h12340008);
    pop(); chk(sts_data == 32'h00770004, "R11 entry 2", sts_data, 32'h00770004);
    pop(); chk(sts_data == 32'h00770004 && sts_level == 0, "R11 empty pop unchanged",
               sts_data, 32'h00770004);

    // R9 overflow: 12 words fill usage, 13th dropped
    wr(32'h00002028);
    wr(32'h11110000);
    for (int k = 0; k < 10; k++) begin
      wr(32'h01010101);
      if (k == 9) chk(!ovf_irq && out_valid, "R9 word at capacity accepted",
                      {31'd0, ovf_irq}, 32'd0);
    end
    wr(32'h00003001);
    chk(ovf_irq && !out_valid, "R9 overflow pulse", {31'd0, ovf_irq}, 32'd1);
    @(negedge clk);
    chk(!ovf_irq, "R9 overflow single cycle", {31'd0, ovf_irq}, 32'd0);

    // R10 clear zeroes usage and re-syncs header parsing
    pulse_clr();
    wr(32'h00003008);
    wr(32'h99990000);
    pulse_clr();
    wr(32'h00003002);
    wr(32'h55550000);
    wr(32'h0000BBAA);
    chk(out_valid && out_data == 32'h0000BBAA && out_keep == 4'h3 && out_last,
        "R10 packet after clear", out_data, 32'h0000BBAA);
    chk(sts_level == 1, "R10 status pushed after clear", 32'(sts_level), 32'd1);

    // R8 status FIFO fills
    for (int t = 1; t <= 3; t++) begin
      wr(32'h00003001);
      wr({16'(t), 16'h0});
      wr(32'h000000E0 + 32'(t));
      if (t == 3)
        chk(sts_full_irq && sts_level == 4, "R8 full pulse at depth",
            {28'd0, sts_full_irq, sts_level}, {28'd0, 1'b1, 3'd4});
      else
        chk(!sts_full_irq, "R8 no full pulse below depth", {31'd0, sts_full_irq}, 32'd0);
    end
    wr(32'h00003001);
    wr(32'h00040000);
    wr(32'h000000E4);
    chk(!sts_full_irq && sts_level == 4, "R8 push while full discarded",
        {28'd0, sts_full_irq, sts_level}, {28'd0, 1'b0, 3'd4});

    pop(); chk(sts_data == 32'h55550002, "R11 pop 0", sts_data, 32'h55550002);
    pop(); chk(sts_data == 32'h00010001, "R11 pop 1", sts_data, 32'h00010001);
    pop(); chk(sts_data == 32'h00020001, "R11 pop 2", sts_data, 32'h00020001);
    pop(); chk(sts_data == 32'h00030001 && sts_level == 0, "R8 dropped entry absent",
               sts_data, 32'h00030001);
    pop(); chk(sts_data == 32'h00030001 && sts_level == 0, "R11 empty pop after drain",
               sts_data, 32'h00030001);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule